// File: doc/BRIEF.md
# Manchester Bitstream Decoder With Clock Recovery

This block takes the single-wire output of a delta-sigma modulator that carries its own clock inside a Manchester code. It oversamples that wire with the much faster system clock and recovers both the data bits and their timing. There is no separate modulator clock pin. The block measures the spacing between transitions to learn and follow the bit period, and it accepts only transitions that fall inside a window around that period as mid-bit transitions.

Each recovered bit is presented with a one-cycle strobe. One control input selects the Manchester convention. With the control low, a rising mid-bit transition is a 1. With it high, a falling one is a 1. The block watches the stream for a dead modulator and for a stream that is far too fast. When it sees either, it raises a sticky failure flag that stays separate from the strobe and holds the strobe off until software pulses a clear input.

Top module: `manchester_clk_recover`

## Requirements
- R1: After reset, `bit_vld`, `bit_out` and `mod_fail` are 0. An idle, unchanging line after reset never raises `mod_fail`.
- R2: With `invert_pol` = 0, a rising transition at mid-bit decodes as 1 and a falling one as 0. Each decoded bit gives exactly one `bit_vld` pulse, and bits come out in line order.
- R3: With `invert_pol` = 1, the mapping is swapped: a falling mid-bit transition decodes as 1 and a rising one as 0.
- R4: A transition that arrives less than 3/4 of the tracked period after the last mid-bit transition is treated as a bit boundary. It produces no strobe, so runs of equal bits decode without extra or missing bits.
- R5: After reset or a clear, the first transition only aligns the decoder and gives no strobe. The decoder then locks to any bit period from 8 to 20 system clocks. For a period it does not accept directly, a later transition that is too late resynchronises it, and no strobe follows that transition either.
- R6: The tracked period follows the average of itself and each accepted mid-to-mid spacing. The decoder therefore keeps lock when each half-bit varies by a clock from bit to bit.
- R7: Once the decoder has seen a transition, `mod_fail` goes to 1 when no transition arrives for more than 24 system clocks.
- R8: Once the decoder has seen a transition, a new transition less than 3 system clocks after the previous one sets `mod_fail`. That gap corresponds to a bit period below 6 clocks. A gap of exactly 3 clocks does not set `mod_fail`.
- R9: `mod_fail` stays set until `fail_clr` is pulsed, and `bit_vld` stays 0 while it is set. The clear also returns the tracked period to 10 clocks and the decoder to its unaligned state.
- R10: The tracked period always lies within 8 to 20 system clocks.
- R11: `bit_vld` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the line |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Asynchronous Manchester data from the modulator |
| invert_pol | input | 1 | Convention select: 0 means a rising mid-bit transition is 1, 1 means a falling one is 1 |
| fail_clr | input | 1 | One-cycle pulse that clears the failure flag and restarts alignment |
| bit_out | output | 1 | Last recovered data bit |
| bit_vld | output | 1 | One-cycle strobe marking a new value on `bit_out` |
| mod_fail | output | 1 | Sticky modulator failure flag |

## Verification
The embedded assertions check four things on every cycle:
- the tracked period never leaves its legal 8 to 20 clock range;
- the strobe is a single-cycle pulse that only follows a detected transition;
- the failure flag holds until it is cleared;
- no strobe appears while the flag is set.

The decoding itself can only be shown by the bench scenarios. These cover both conventions, random data with repeated bits, and periods of 8, 9, 10 and 20 clocks. They also include half-bits that wander by a clock, a line that goes quiet, a narrow glitch, and a stream whose half-bit is exactly 3 clocks long.

// File: rtl/manchester_clk_recover.sv
`timescale 1ns/1ps
module manchester_clk_recover #(
  parameter int MIN_PER    = 8,
  parameter int MAX_PER    = 20,
  parameter int NOM_PER    = 10,
  parameter int IDLE_LIM   = 24,
  parameter int MIN_PERIOD = 6,
  parameter int CW         = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic invert_pol,
  input  logic fail_clr,
  output logic bit_out,
  output logic bit_vld,
  output logic mod_fail
);
  localparam int MW = CW + 3;
  localparam logic [CW-1:0] MIN_C  = CW'(MIN_PER);
  localparam logic [CW-1:0] MAX_C  = CW'(MAX_PER);
  localparam logic [CW-1:0] NOM_C  = CW'(NOM_PER);
  localparam logic [CW-1:0] IDLE_C = CW'(IDLE_LIM);
  localparam logic [CW-1:0] HALF_C = CW'(MIN_PERIOD / 2);
  localparam logic [CW-1:0] SAT_C  = '1;

  logic [2:0]    sh;
  logic [CW-1:0] cnt, gap, per;
  logic          locked;

  wire          edge_d = sh[2] ^ sh[1];
  wire          rise   = sh[1] & ~sh[2];
  wire [MW-1:0] c4     = MW'(cnt) << 2;
  wire [MW-1:0] p3     = MW'(per) * MW'(3);
  wire [MW-1:0] p5     = MW'(per) * MW'(5);
  wire          in_win = (c4 >= p3) && (c4 <= p5);
  wire          late   = c4 > p5;
  wire          acc    = edge_d && locked && in_win;
  wire          relock = edge_d && (!locked || late);
  wire          legal  = (cnt >= MIN_C) && (cnt <= MAX_C);
  wire [CW:0]   sum    = {1'b0, per} + {1'b0, cnt};
  wire          fail_set = locked && ((edge_d && gap < HALF_C) || gap > IDLE_C);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh       <= '0;
      cnt      <= '0;
      gap      <= '0;
      per      <= NOM_C;
      locked   <= 1'b0;
      mod_fail <= 1'b0;
      bit_vld  <= 1'b0;
      bit_out  <= 1'b0;
    end else begin
      sh <= {sh[1:0], line_in};

      if (edge_d && (acc || relock)) cnt <= CW'(1);
      else if (cnt != SAT_C)         cnt <= cnt + 1'b1;

      if (edge_d)              gap <= CW'(1);
      else if (gap != SAT_C)   gap <= gap + 1'b1;

      if (fail_clr)                     per <= NOM_C;
      else if (acc && legal)            per <= sum[CW:1];
      else if (relock && locked && legal) per <= cnt;

      if (fail_clr)    locked <= 1'b0;
      else if (edge_d) locked <= 1'b1;

      if (fail_clr)      mod_fail <= 1'b0;
      else if (fail_set) mod_fail <= 1'b1;

      bit_vld <= acc && !mod_fail && !fail_set;
      if (acc) bit_out <= rise ^ invert_pol;
    end
  end

  a_r10_period_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (per >= MIN_C) && (per <= MAX_C));

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |=> !bit_vld);

  a_r2_vld_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |-> $past(edge_d));

  a_r9_sticky_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_fail && !fail_clr) |=> mod_fail);

  a_r9_no_vld_in_fail: assert property (@(posedge clk) disable iff (!rst_n)
    mod_fail |-> !bit_vld);
endmodule

// File: tb/test_manchester_clk_recover.sv
`timescale 1ns/1ps
module test_manchester_clk_recover;
  logic clk = 1'b0, rst_n = 1'b0, line_in = 1'b0, invert_pol = 1'b0, fail_clr = 1'b0;
  logic bit_out, bit_vld, mod_fail;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;
  bit got[$];
  bit expq[$];

  always #4 clk = ~clk;

  manchester_clk_recover i_manchester_clk_recover (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .invert_pol(invert_pol),
    .fail_clr(fail_clr), .bit_out(bit_out), .bit_vld(bit_vld), .mod_fail(mod_fail));

  always @(negedge clk) if (rst_n && bit_vld) got.push_back(bit_out);

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int pick(input int lo, input int hi);
    return lo + int'($urandom % (hi - lo + 1));
  endfunction

  task automatic send_bit(input bit b, input int h1, input int h2);
    line_in = ~(b ^ invert_pol);
    ticks(h1);
    line_in = b ^ invert_pol;
    ticks(h2);
  endtask

  task automatic start_stream(input bit inv, input bit b0);
    invert_pol = inv;
    line_in = ~(b0 ^ inv);
    ticks(4);
    fail_clr = 1'b1;
    ticks(1);
    fail_clr = 1'b0;
    ticks(2);
    got.delete();
    expq.delete();
  endtask

  task automatic run(input string req, input bit inv, input int npre, input int ndat,
                     input int hlo, input int hhi, input bit exact);
    bit b0, b;
    int ok, base;
    b0 = bit'($urandom % 2);
    start_stream(inv, b0);
    for (int k = 0; k < npre; k++) begin
      b = b0 ^ bit'(k % 2);
      if (k > 0) expq.push_back(b);
      send_bit(b, pick(hlo, hhi), pick(hlo, hhi));
    end
    for (int k = 0; k < ndat; k++) begin
      b = bit'($urandom % 2);
      expq.push_back(b);
      send_bit(b, pick(hlo, hhi), pick(hlo, hhi));
    end
    ticks(3);
    check({req, " no failure during stream"}, int'(mod_fail), 0);
    if (exact) check({req, " strobe count"}, got.size(), expq.size());
    else begin
      ok = (got.size() >= ndat && got.size() <= expq.size()) ? 1 : 0;
      check({req, " strobe count in range"}, ok, 1);
    end
    if (got.size() >= ndat) begin
      base = got.size() - ndat;
      for (int k = 0; k < ndat; k++)
        check({req, " data bit"}, int'(got[base + k]), int'(expq[npre - 1 + k]));
    end
    ticks(30);
    check("R7 failure after line goes quiet", int'(mod_fail), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    ticks(3);
    rst_n = 1'b1;
    ticks(1);
    check("R1 reset bit_vld", int'(bit_vld), 0);
    check("R1 reset bit_out", int'(bit_out), 0);
    check("R1 reset mod_fail", int'(mod_fail), 0);
    ticks(40);
    check("R1 idle line after reset keeps mod_fail low", int'(mod_fail), 0);

    run("R2 R4 R5 ieee period 10", 1'b0, 8, 60, 5, 5, 1'b1);
    run("R3 R4 inverted period 10", 1'b1, 8, 60, 5, 5, 1'b1);
    run("R5 period 8", 1'b0, 8, 40, 4, 4, 1'b0);
    run("R5 period 20", 1'b0, 8, 40, 10, 10, 1'b0);
    run("R5 period 9 wobble", 1'b1, 8, 40, 4, 5, 1'b0);
    run("R6 half-bit drift", 1'b0, 8, 80, 5, 6, 1'b0);

    got.delete();
    for (int k = 0; k < 10; k++) send_bit(bit'(k % 2), 5, 5);
    ticks(3);
    check("R9 no strobe while failed", got.size(), 0);
    check("R9 flag sticky without clear", int'(mod_fail), 1);

    start_stream(1'b0, 1'b1);
    for (int k = 0; k < 8; k++) send_bit(bit'((k + 1) % 2), 5, 5);
    ticks(3);
    check("R8 stream before glitch ok", int'(mod_fail), 0);
    check("R8 strobes before glitch", got.size(), 7);
    line_in = ~line_in;
    ticks(1);
    line_in = ~line_in;
    ticks(6);
    check("R8 narrow glitch sets failure", int'(mod_fail), 1);

    start_stream(1'b0, 1'b0);
    for (int k = 0; k < 30; k++) send_bit(bit'($urandom % 2), 3, 3);
    ticks(2);
    check("R8 three-clock spacing is not a failure", int'(mod_fail), 0);

    run("R2 R9 recovery after clear", 1'b0, 8, 30, 5, 5, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule